// File: doc/BRIEF.md
# Group Register Rename Unit

This block renames four instructions per cycle for an out-of-order core. Every slot carries two source register fields and one destination field. A mapping table holds one entry for each architectural register. An entry either points at the architectural register file or names the physical tag of the newest version of that register. Sources look up the table. Each destination that writes takes the next tag offered by an external free-register pool, in slot order.

Inside one group, a comparator network replaces a table lookup with the tag of the youngest older slot that writes the same register. Only the last writer of each register in the group updates the table. When a slot is a branch, the block saves a copy of the whole mapping in a checkpoint slot. That copy is the mapping seen after the branch. A mispredict restores the table from the checkpoint and releases that checkpoint and every younger one. A correct resolution releases only the branch's own checkpoint. Rename results are combinational in the cycle the group is presented. The table and the checkpoints change at the next clock edge.

Top module: `group_renamer`

## Requirements
- R1: After reset every table entry reads as "in architectural file" (arf flag 1, tag 0), and all checkpoints are free.
- R2: When a group is accepted, the k-th valid slot that writes a destination (k counted from 0 in slot order) gets tag `pool_tags[k]`. `pool_pop` then equals the number of such slots. When no group is accepted, `pool_pop` is 0.
- R3: A source of slot i that matches the destination of a valid writing slot j<i in the same group reads arf flag 0 and the tag of the largest such j.
- R4: A source with no in-group match reads the table entry, which holds the tag from the last writer of that register in earlier accepted groups.
- R5: If `grp_b_imm` is set, source B reads arf flag 0. Its tag is the B field zero-extended, and the field is never compared with destinations.
- R6: Invalid slots and slots without `grp_dst_we` take no tag and write nothing. Their destination tag output is 0. Invalid slots never act as override sources.
- R7: `stall` is 1 when `mp_valid` is 1. It is also 1 when any slot is valid and either `pool_count` is less than 4 or fewer checkpoints are free than there are valid branch slots. A stalled group changes neither the table nor the checkpoints.
- R8: Valid branch slots take the lowest-numbered free checkpoints in slot order. Each snapshot holds the mapping after all writers up to and including the branch slot. Non-branch slots report checkpoint 0.
- R9: On `mp_valid` the table takes the contents of checkpoint `mp_ckpt` at the next edge. That checkpoint and every checkpoint allocated after it become free. Older checkpoints stay allocated.
- R10: On `br_ok_valid` checkpoint `br_ok_ckpt` becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 4 | Slot valid bits |
| grp_dst_we | input | 4 | Slot writes a destination |
| grp_is_br | input | 4 | Slot is a branch and needs a checkpoint |
| grp_b_imm | input | 4 | Source B is an immediate |
| grp_src_a | input | 4x4 | Source A register per slot |
| grp_src_b | input | 4x4 | Source B register or immediate per slot |
| grp_dst | input | 4x4 | Destination register per slot |
| pool_count | input | 3 | Number of tags offered by the free pool (0..4) |
| pool_tags | input | 4x6 | Offered tags, oldest first |
| mp_valid | input | 1 | Mispredict restore request |
| mp_ckpt | input | 2 | Checkpoint to restore |
| br_ok_valid | input | 1 | Branch resolved correctly |
| br_ok_ckpt | input | 2 | Checkpoint to release |
| stall | output | 1 | Group not accepted this cycle |
| pool_pop | output | 3 | Tags consumed this cycle |
| ren_a_arf | output | 4 | Source A reads the architectural file |
| ren_a_tag | output | 4x6 | Source A physical tag |
| ren_b_arf | output | 4 | Source B reads the architectural file |
| ren_b_tag | output | 4x6 | Source B physical tag or immediate |
| ren_dst_tag | output | 4x6 | Destination tag per slot |
| ren_ckpt | output | 4x2 | Checkpoint given to each branch slot |

## Verification
The embedded properties watch the following on every cycle:
- no register takes two table writes from one group;
- the table stays still when nothing writes it;
- a restore loads the checkpoint that was named;
- released checkpoints read back free;
- two branches of one group never share a checkpoint;
- the pool is never popped beyond its count.

Some behaviour shows only through the bench's scenarios, checked against a sequential reference model:
- which tag a source receives when several older slots write the same register;
- whether a snapshot includes the branch slot's own write;
- whether a mispredict frees exactly the younger checkpoints.

// File: rtl/rn_pkg.sv
package rn_pkg;
   localparam int DEF_GROUP     = 4;
   localparam int DEF_ARCH_REGS = 16;
   localparam int DEF_TAG_W     = 6;
   localparam int DEF_CKPTS     = 4;

   // Entry layout of the mapping table: {in_arf, tag}
   function automatic int entry_width(input int tag_w);
      return tag_w + 1;
   endfunction
endpackage

// File: rtl/rn_intra_dep.sv
module rn_intra_dep #(
   parameter int GROUP = 4,
   parameter int AW    = 4,
   parameter int TAG_W = 6,
   localparam int CW   = $clog2(GROUP + 1)
) (
   input  logic [GROUP-1:0]            valid,
   input  logic [GROUP-1:0]            dst_we,
   input  logic [GROUP-1:0]            b_imm,
   input  logic [GROUP-1:0][AW-1:0]    src_a,
   input  logic [GROUP-1:0][AW-1:0]    src_b,
   input  logic [GROUP-1:0][AW-1:0]    dst,
   input  logic [GROUP-1:0][TAG_W-1:0] pool_tags,
   input  logic [GROUP-1:0]            tbl_a_arf,
   input  logic [GROUP-1:0][TAG_W-1:0] tbl_a_tag,
   input  logic [GROUP-1:0]            tbl_b_arf,
   input  logic [GROUP-1:0][TAG_W-1:0] tbl_b_tag,
   output logic [GROUP-1:0]            a_arf,
   output logic [GROUP-1:0][TAG_W-1:0] a_tag,
   output logic [GROUP-1:0]            b_arf,
   output logic [GROUP-1:0][TAG_W-1:0] b_tag,
   output logic [GROUP-1:0][TAG_W-1:0] dst_tag,
   output logic [GROUP-1:0]            last_wr,
   output logic [CW-1:0]               n_wr
);
   logic [GROUP-1:0] wr;
   assign wr = valid & dst_we;

   // tag hand-out in slot order
   always_comb begin : p_tags
      int k;
      k = 0;
      for (int i = 0; i < GROUP; i++) begin
         dst_tag[i] = '0;
         if (wr[i]) begin
            for (int j = 0; j < GROUP; j++)
               if (j == k) dst_tag[i] = pool_tags[j];
            k++;
         end
      end
      n_wr = CW'(k);
   end

   // source override: ascending scan so the youngest older writer wins
   always_comb begin : p_src
      for (int i = 0; i < GROUP; i++) begin
         a_arf[i] = tbl_a_arf[i];
         a_tag[i] = tbl_a_tag[i];
         b_arf[i] = tbl_b_arf[i];
         b_tag[i] = tbl_b_tag[i];
         for (int j = 0; j < GROUP; j++) begin
            if (j < i && wr[j] && dst[j] == src_a[i]) begin
               a_arf[i] = 1'b0;
               a_tag[i] = dst_tag[j];
            end
            if (j < i && wr[j] && dst[j] == src_b[i]) begin
               b_arf[i] = 1'b0;
               b_tag[i] = dst_tag[j];
            end
         end
         if (b_imm[i]) begin
            b_arf[i] = 1'b0;
            b_tag[i] = TAG_W'(src_b[i]);
         end
      end
   end

   // last writer of each register in the group
   always_comb begin : p_last
      for (int i = 0; i < GROUP; i++) begin
         last_wr[i] = wr[i];
         for (int j = 0; j < GROUP; j++)
            if (j > i && wr[j] && dst[j] == dst[i]) last_wr[i] = 1'b0;
      end
   end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
   parameter int GROUP = 4,
   parameter int NREG  = 16,
   parameter int TAG_W = 6,
   parameter int NCK   = 4,
   localparam int AW   = $clog2(NREG),
   localparam int KW   = (NCK > 1) ? $clog2(NCK) : 1,
   localparam int EW   = rn_pkg::entry_width(TAG_W)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [GROUP-1:0][AW-1:0]    rd_a,
   input  logic [GROUP-1:0][AW-1:0]    rd_b,
   output logic [GROUP-1:0]            rd_a_arf,
   output logic [GROUP-1:0][TAG_W-1:0] rd_a_tag,
   output logic [GROUP-1:0]            rd_b_arf,
   output logic [GROUP-1:0][TAG_W-1:0] rd_b_tag,
   input  logic [GROUP-1:0]            wr_en,
   input  logic [GROUP-1:0]            lw_en,
   input  logic [GROUP-1:0][AW-1:0]    wr_dst,
   input  logic [GROUP-1:0][TAG_W-1:0] wr_tag,
   input  logic [GROUP-1:0]            snap_en,
   input  logic [GROUP-1:0][KW-1:0]    snap_id,
   input  logic                        restore,
   input  logic [KW-1:0]               restore_id
);
   localparam logic [EW-1:0] ARF_ENTRY = {1'b1, {TAG_W{1'b0}}};

   logic [EW-1:0] tbl_q [NREG];
   logic [EW-1:0] ck_q  [NCK][NREG];
   logic [EW-1:0] view  [GROUP][NREG];

   // 2*GROUP read ports
   always_comb begin : p_read
      for (int i = 0; i < GROUP; i++) begin
         {rd_a_arf[i], rd_a_tag[i]} = tbl_q[rd_a[i]];
         {rd_b_arf[i], rd_b_tag[i]} = tbl_q[rd_b[i]];
      end
   end

   // mapping as seen just after each slot, for branch snapshots
   always_comb begin : p_view
      logic [EW-1:0] e;
      for (int j = 0; j < GROUP; j++) begin
         for (int r = 0; r < NREG; r++) begin
            e = tbl_q[r];
            for (int k = 0; k < GROUP; k++)
               if (k <= j && wr_en[k] && wr_dst[k] == AW'(r)) e = {1'b0, wr_tag[k]};
            view[j][r] = e;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) tbl_q[r] <= ARF_ENTRY;
      end else if (restore) begin
         for (int r = 0; r < NREG; r++) tbl_q[r] <= ck_q[restore_id][r];
      end else begin
         for (int k = 0; k < GROUP; k++)
            if (lw_en[k]) tbl_q[wr_dst[k]] <= {1'b0, wr_tag[k]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCK; c++)
            for (int r = 0; r < NREG; r++) ck_q[c][r] <= ARF_ENTRY;
      end else begin
         for (int k = 0; k < GROUP; k++)
            if (snap_en[k])
               for (int r = 0; r < NREG; r++) ck_q[snap_id[k]][r] <= view[k][r];
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_chk
      logic [GROUP-1:0] hit;
      always_comb begin
         for (int k = 0; k < GROUP; k++) hit[k] = lw_en[k] && (wr_dst[k] == AW'(r));
      end
      AST_ONE_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(hit) <= 1); // R4
      AST_TABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (!restore && !(|lw_en)) |=> (tbl_q[r] == $past(tbl_q[r]))); // R7
      AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         restore |=> (tbl_q[r] == $past(ck_q[restore_id][r]))); // R9
   end
endmodule

// File: rtl/rn_ckpt_alloc.sv
module rn_ckpt_alloc #(
   parameter int GROUP = 4,
   parameter int NCK   = 4,
   localparam int KW   = (NCK > 1) ? $clog2(NCK) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [GROUP-1:0]         br_req,
   input  logic                     take,
   input  logic                     mp_valid,
   input  logic [KW-1:0]            mp_id,
   input  logic                     ok_valid,
   input  logic [KW-1:0]            ok_id,
   output logic [GROUP-1:0][KW-1:0] ck_id,
   output logic                     enough
);
   logic [NCK-1:0] free_q;
   logic [NCK-1:0] older_q [NCK];   // older_q[a][b]: a allocated before b
   logic [NCK-1:0] live    [GROUP]; // live set seen by each slot's allocation

   always_comb begin : p_pick
      logic [NCK-1:0] avail;
      logic           found;
      avail = free_q;
      found = 1'b0;
      for (int i = 0; i < GROUP; i++) begin
         ck_id[i] = '0;
         live[i]  = ~avail;
         found    = 1'b0;
         if (br_req[i]) begin
            for (int c = 0; c < NCK; c++) begin
               if (!found && avail[c]) begin
                  ck_id[i] = KW'(c);
                  avail[c] = 1'b0;
                  found    = 1'b1;
               end
            end
         end
      end
   end

   assign enough = $countones(br_req) <= $countones(free_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= '1;
         for (int a = 0; a < NCK; a++) older_q[a] <= '0;
      end else begin
         if (take) begin
            for (int i = 0; i < GROUP; i++) begin
               if (br_req[i]) begin
                  free_q[ck_id[i]]  <= 1'b0;
                  older_q[ck_id[i]] <= '0;
                  for (int x = 0; x < NCK; x++) older_q[x][ck_id[i]] <= live[i][x];
               end
            end
         end
         if (mp_valid) begin
            free_q[mp_id] <= 1'b1;
            for (int x = 0; x < NCK; x++)
               if (older_q[mp_id][x]) free_q[x] <= 1'b1;
         end
         if (ok_valid) free_q[ok_id] <= 1'b1;
      end
   end

   AST_MP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      mp_valid |=> free_q[$past(mp_id)]); // R9
   AST_OK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ok_valid |=> free_q[$past(ok_id)]); // R10

   for (genvar i = 0; i < GROUP; i++) begin : g_pair_i
      for (genvar j = i + 1; j < GROUP; j++) begin : g_pair_j
         AST_DISTINCT_CKPT: assert property (@(posedge clk) disable iff (!rst_n)
            (take && br_req[i] && br_req[j]) |-> (ck_id[i] != ck_id[j])); // R8
      end
   end
endmodule

// File: rtl/group_renamer.sv
module group_renamer import rn_pkg::*; #(
   parameter int GROUP     = DEF_GROUP,
   parameter int ARCH_REGS = DEF_ARCH_REGS,
   parameter int TAG_W     = DEF_TAG_W,
   parameter int CKPTS     = DEF_CKPTS,
   localparam int AW       = $clog2(ARCH_REGS),
   localparam int KW       = (CKPTS > 1) ? $clog2(CKPTS) : 1,
   localparam int CW       = $clog2(GROUP + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [GROUP-1:0]            grp_valid,
   input  logic [GROUP-1:0]            grp_dst_we,
   input  logic [GROUP-1:0]            grp_is_br,
   input  logic [GROUP-1:0]            grp_b_imm,
   input  logic [GROUP-1:0][AW-1:0]    grp_src_a,
   input  logic [GROUP-1:0][AW-1:0]    grp_src_b,
   input  logic [GROUP-1:0][AW-1:0]    grp_dst,
   input  logic [CW-1:0]               pool_count,
   input  logic [GROUP-1:0][TAG_W-1:0] pool_tags,
   input  logic                        mp_valid,
   input  logic [KW-1:0]               mp_ckpt,
   input  logic                        br_ok_valid,
   input  logic [KW-1:0]               br_ok_ckpt,
   output logic                        stall,
   output logic [CW-1:0]               pool_pop,
   output logic [GROUP-1:0]            ren_a_arf,
   output logic [GROUP-1:0][TAG_W-1:0] ren_a_tag,
   output logic [GROUP-1:0]            ren_b_arf,
   output logic [GROUP-1:0][TAG_W-1:0] ren_b_tag,
   output logic [GROUP-1:0][TAG_W-1:0] ren_dst_tag,
   output logic [GROUP-1:0][KW-1:0]    ren_ckpt
);
   initial begin : p_param_check
      if (TAG_W < AW)              $fatal(1, "tag width below register index width");
      if (ARCH_REGS != (1 << AW))  $fatal(1, "register count must be a power of two");
      if (CKPTS != (1 << KW))      $fatal(1, "checkpoint count must be a power of two");
      if (GROUP < 1)               $fatal(1, "group must hold at least one slot");
   end

   logic                        any_v, take, ck_enough;
   logic [GROUP-1:0]            br_req, last_wr, wr_acc, lw_acc, snap_acc;
   logic [GROUP-1:0]            tbl_a_arf, tbl_b_arf;
   logic [GROUP-1:0][TAG_W-1:0] tbl_a_tag, tbl_b_tag;
   logic [CW-1:0]               n_wr;

   assign any_v    = |grp_valid;
   assign br_req   = grp_valid & grp_is_br;
   assign stall    = mp_valid | (any_v & ((pool_count < CW'(GROUP)) | ~ck_enough));
   assign take     = any_v & ~stall;
   assign wr_acc   = {GROUP{take}} & grp_valid & grp_dst_we;
   assign lw_acc   = {GROUP{take}} & last_wr;
   assign snap_acc = {GROUP{take}} & br_req;
   assign pool_pop = take ? n_wr : '0;

   rn_map_table #(.GROUP(GROUP), .NREG(ARCH_REGS), .TAG_W(TAG_W), .NCK(CKPTS)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_a       (grp_src_a),
      .rd_b       (grp_src_b),
      .rd_a_arf   (tbl_a_arf),
      .rd_a_tag   (tbl_a_tag),
      .rd_b_arf   (tbl_b_arf),
      .rd_b_tag   (tbl_b_tag),
      .wr_en      (wr_acc),
      .lw_en      (lw_acc),
      .wr_dst     (grp_dst),
      .wr_tag     (ren_dst_tag),
      .snap_en    (snap_acc),
      .snap_id    (ren_ckpt),
      .restore    (mp_valid),
      .restore_id (mp_ckpt)
   );

   rn_intra_dep #(.GROUP(GROUP), .AW(AW), .TAG_W(TAG_W)) u_dep (
      .valid     (grp_valid),
      .dst_we    (grp_dst_we),
      .b_imm     (grp_b_imm),
      .src_a     (grp_src_a),
      .src_b     (grp_src_b),
      .dst       (grp_dst),
      .pool_tags (pool_tags),
      .tbl_a_arf (tbl_a_arf),
      .tbl_a_tag (tbl_a_tag),
      .tbl_b_arf (tbl_b_arf),
      .tbl_b_tag (tbl_b_tag),
      .a_arf     (ren_a_arf),
      .a_tag     (ren_a_tag),
      .b_arf     (ren_b_arf),
      .b_tag     (ren_b_tag),
      .dst_tag   (ren_dst_tag),
      .last_wr   (last_wr),
      .n_wr      (n_wr)
   );

   rn_ckpt_alloc #(.GROUP(GROUP), .NCK(CKPTS)) u_ckpt (
      .clk      (clk),
      .rst_n    (rst_n),
      .br_req   (br_req),
      .take     (take),
      .mp_valid (mp_valid),
      .mp_id    (mp_ckpt),
      .ok_valid (br_ok_valid),
      .ok_id    (br_ok_ckpt),
      .ck_id    (ren_ckpt),
      .enough   (ck_enough)
   );

   AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pool_pop <= pool_count); // R2
endmodule

// File: tb/group_renamer_tb.sv
`timescale 1ns/1ps
module group_renamer_tb;
   localparam int G = 4, NR = 16, PW = 6, NK = 4, AW = 4, KW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [G-1:0]          v, we, br, im;
   logic [G-1:0][AW-1:0]  sa, sb, sd;
   logic [2:0]            pc;
   logic [G-1:0][PW-1:0]  pt;
   logic                  mp_v, ok_v;
   logic [KW-1:0]         mp_id, ok_id;

   logic                  stall;
   logic [2:0]            pool_pop;
   logic [G-1:0]          a_arf, b_arf;
   logic [G-1:0][PW-1:0]  a_tag, b_tag, d_tag;
   logic [G-1:0][KW-1:0]  ck;

   group_renamer u_dut (
      .clk(clk), .rst_n(rst_n), .grp_valid(v), .grp_dst_we(we), .grp_is_br(br),
      .grp_b_imm(im), .grp_src_a(sa), .grp_src_b(sb), .grp_dst(sd),
      .pool_count(pc), .pool_tags(pt), .mp_valid(mp_v), .mp_ckpt(mp_id),
      .br_ok_valid(ok_v), .br_ok_ckpt(ok_id), .stall(stall), .pool_pop(pool_pop),
      .ren_a_arf(a_arf), .ren_a_tag(a_tag), .ren_b_arf(b_arf), .ren_b_tag(b_tag),
      .ren_dst_tag(d_tag), .ren_ckpt(ck)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   logic [PW:0]   m_tbl [NR];
   logic [PW:0]   m_ck  [NK][NR];
   logic [NK-1:0] m_free;
   int            m_seq [NK];
   int            seq_ctr = 0;
   bit            after_mp = 0;

   // expectations of the current cycle
   logic          e_stall, e_take;
   logic [2:0]    e_pop;
   logic [PW:0]   e_a [G];
   logic [PW:0]   e_b [G];
   logic [PW-1:0] e_d [G];
   logic [KW-1:0] e_k [G];
   bit            e_ahit [G];
   bit            e_bhit [G];
   logic [PW:0]   n_tbl [NR];
   logic [PW:0]   n_snap [G][NR];

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   // sequential renaming, slot by slot, against a working copy of the table
   task automatic predict();
      logic [PW:0]   cur [NR];
      logic [NK-1:0] fa;
      logic [NR-1:0] gw;
      int            k;
      bit            found;
      cur = m_tbl;
      fa  = m_free;
      gw  = '0;
      k   = 0;
      e_stall = mp_v | ((|v) & ((pc < 3'd4) | ($countones(v & br) > $countones(m_free))));
      e_take  = (|v) & ~e_stall;
      for (int i = 0; i < G; i++) begin
         e_a[i]    = cur[sa[i]];
         e_ahit[i] = gw[sa[i]];
         if (im[i]) begin
            e_b[i] = {1'b0, PW'(sb[i])};
            e_bhit[i] = 1'b1;
         end else begin
            e_b[i] = cur[sb[i]];
            e_bhit[i] = gw[sb[i]];
         end
         e_d[i] = '0;
         if (v[i] && we[i]) begin
            e_d[i] = pt[k];
            k++;
            cur[sd[i]] = {1'b0, e_d[i]};
            gw[sd[i]] = 1'b1;
         end
         e_k[i] = '0;
         if (v[i] && br[i]) begin
            found = 0;
            for (int c = 0; c < NK; c++)
               if (!found && fa[c]) begin
                  e_k[i] = KW'(c);
                  fa[c] = 1'b0;
                  found = 1;
               end
         end
         n_snap[i] = cur;
      end
      n_tbl = cur;
      e_pop = e_take ? 3'(k) : 3'd0;
   endtask

   task automatic commit();
      int sq;
      if (mp_v) begin
         m_tbl = m_ck[mp_id];
         sq = m_seq[mp_id];
         for (int c = 0; c < NK; c++)
            if (!m_free[c] && m_seq[c] > sq) m_free[c] = 1'b1;
         m_free[mp_id] = 1'b1;
      end else if (e_take) begin
         m_tbl = n_tbl;
         for (int i = 0; i < G; i++)
            if (v[i] && br[i]) begin
               m_ck[e_k[i]]   = n_snap[i];
               m_free[e_k[i]] = 1'b0;
               m_seq[e_k[i]]  = seq_ctr;
               seq_ctr++;
            end
      end
      if (ok_v) m_free[ok_id] = 1'b1;
   endtask

   task automatic step(input string lbl);
      string rq;
      predict();
      #2;
      chk("R7", "stall", 32'(stall), 32'(e_stall));
      chk("R2", "pool_pop", 32'(pool_pop), 32'(e_pop));
      if (e_take) begin
         for (int i = 0; i < G; i++) begin
            if (v[i]) begin
               rq = (lbl != "") ? lbl : e_ahit[i] ? "R3" : after_mp ? "R9" : "R4";
               chk(rq, $sformatf("src_a slot%0d", i), 32'({a_arf[i], a_tag[i]}), 32'(e_a[i]));
               rq = (lbl != "") ? lbl : im[i] ? "R5" : e_bhit[i] ? "R3" : after_mp ? "R9" : "R4";
               chk(rq, $sformatf("src_b slot%0d", i), 32'({b_arf[i], b_tag[i]}), 32'(e_b[i]));
            end
            rq = (v[i] && we[i]) ? "R2" : "R6";
            chk(rq, $sformatf("dst slot%0d", i), 32'(d_tag[i]), 32'(e_d[i]));
            rq = (lbl != "") ? lbl : "R8";
            chk(rq, $sformatf("ckpt slot%0d", i), 32'(ck[i]), 32'(e_k[i]));
         end
      end
      after_mp = mp_v;
      @(posedge clk);
      commit();
      @(negedge clk);
   endtask

   task automatic idle();
      v = '0; we = '0; br = '0; im = '0;
      sa = '0; sb = '0; sd = '0;
      pc = 3'd4;
      for (int i = 0; i < G; i++) pt[i] = PW'(8 + i);
      mp_v = 1'b0; ok_v = 1'b0; mp_id = '0; ok_id = '0;
   endtask

   task automatic pick_live(output logic [KW-1:0] id);
      id = KW'($urandom % NK);
      while (m_free[id]) id = KW'($urandom % NK);
   endtask

   initial begin : p_watchdog
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : p_main
      void'($urandom(32'd20240611));
      idle();
      for (int r = 0; r < NR; r++) m_tbl[r] = {1'b1, {PW{1'b0}}};
      for (int c = 0; c < NK; c++) begin
         m_seq[c] = 0;
         for (int r = 0; r < NR; r++) m_ck[c][r] = {1'b1, {PW{1'b0}}};
      end
      m_free = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every register reads from the architectural file after reset
      for (int g = 0; g < NR / G; g++) begin
         idle();
         v = '1;
         for (int i = 0; i < G; i++) begin
            sa[i] = AW'(g * G + i);
            sb[i] = AW'(NR - 1 - (g * G + i));
         end
         step("R1");
      end
      // R1: all checkpoints free, taken lowest first (ids 0..3)
      idle(); v = '1; br = '1; step("R1");
      // R7: no checkpoint left for a branch
      idle(); v = 4'b0001; br = 4'b0001; step("");
      // R10: release checkpoint 2, next branch must take it
      idle(); ok_v = 1'b1; ok_id = 2'd2; step("");
      idle(); v = 4'b0010; br = 4'b0010; step("R10");
      // R9: mispredict on the oldest frees everything younger
      idle(); mp_v = 1'b1; mp_id = 2'd0; step("");
      idle(); v = '1; br = '1; step("R9");
      idle(); mp_v = 1'b1; mp_id = 2'd0; step("");
      // R3: chain of dependent writers inside one group
      idle(); v = '1; we = '1;
      sa[0] = 4'd2; sb[0] = 4'd1; sd[0] = 4'd1;
      sa[1] = 4'd1; sb[1] = 4'd2; sd[1] = 4'd2;
      sa[2] = 4'd2; sb[2] = 4'd1; sd[2] = 4'd1;
      sa[3] = 4'd2; sb[3] = 4'd1; sd[3] = 4'd1;
      pt[0] = 6'd10; pt[1] = 6'd31; pt[2] = 6'd19; pt[3] = 6'd6;
      step("");
      // R4: only last writers reached the table
      idle(); v = 4'b0011; sa[0] = 4'd1; sb[0] = 4'd2; sa[1] = 4'd2; sb[1] = 4'd1; step("R4");
      // R7: pool short by one tag; then show the table was untouched
      idle(); v = 4'b0001; we = 4'b0001; sd[0] = 4'd1; pc = 3'd3; step("");
      idle(); v = 4'b0001; sa[0] = 4'd1; step("R7");
      // R5: immediate is not overridden by an older writer of the same index
      idle(); v = 4'b0011; we = 4'b0001; sd[0] = 4'd5; im = 4'b0010; sb[1] = 4'd5; step("R5");
      // R6: invalid writer takes no tag and overrides nothing
      idle(); v = 4'b0110; we = 4'b1111; sd = {4'd3, 4'd3, 4'd3, 4'd3}; sa[1] = 4'd3; sa[2] = 4'd3; step("");

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         idle();
         v  = G'($urandom);
         we = G'($urandom);
         br = G'($urandom) & G'($urandom) & G'($urandom);
         im = G'($urandom) & G'($urandom);
         for (int i = 0; i < G; i++) begin
            sa[i] = AW'($urandom % 6);
            sb[i] = AW'($urandom % 6);
            sd[i] = AW'($urandom % 6);
            pt[i] = PW'($urandom);
         end
         pc = ($urandom % 8 == 0) ? 3'($urandom % 4) : 3'd4;
         if (m_free != '1 && $urandom % 10 == 0) begin
            mp_v = 1'b1;
            pick_live(mp_id);
         end
         if (m_free != '1 && $urandom % 4 == 0) begin
            pick_live(ok_id);
            ok_v = !(mp_v && ok_id == mp_id);
         end
         step("");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule